// File: doc/BRIEF.md
# Horizontal microprogrammed control sequencer

This block sequences the control of a single-bus accumulator machine from a small fixed control store. A microprogram counter addresses the store. Each microinstruction is wide and binary-encoded. The block expands its fields into individual strobes: bus-driver enables, register load enables, loads for the memory-side and temporary registers, read and write commands, an ALU function code, a constant-or-bus mux select and a wait-for-memory indication. The datapath, the ALU and the memory are outside the block. Only the strobes leave it.

Three named states drive the sequencer. IDLE waits for a start request. RUN presents one microinstruction per cycle. DONE lasts one cycle and signals completion. The transitions are:
- IDLE to RUN on start.
- RUN to RUN while a routine advances or stalls.
- RUN to DONE when a word carrying the end bit is released.
- DONE to IDLE unconditionally.

Microcode flow control offers absolute jumps and two's-complement relative branches. Either kind can be unconditional or conditioned on one of four datapath status flags.

The store holds a fixed program:
- An instruction fetch routine.
- A program-counter increment routine.
- A short test section that exercises every flow-control form.

Top module: `ucseq_ctrl`

## Requirements
- R1: During and after reset the block is in IDLE with upc 0, busy and done low and every strobe low. It stays there until start is sampled high at a clock edge, and upc is still 0 in the first RUN cycle.
- R2: The driver field (codes 1 to 8 for R0 to R7, 9 PC, 10 MDR, 11 TR0, 12 TR1, any other value none) drives drv_en one-hot: bits 0 to 7 are R0 to R7, bit 8 PC, bit 9 MDR, bit 10 TR0, bit 11 TR1. At most one bit is set.
- R3: The load field (codes 1 to 8 for R0 to R7, 9 PC, 10 IR, any other value none) drives ld_en one-hot: bits 0 to 7 are R0 to R7, bit 8 PC, bit 9 IR.
- R4: The temporary-load field (1 MAR, 2 MDR, 3 TR0, 4 accumulator, other values none) drives tmp_ld with bit 0 MAR, bit 1 MDR, bit 2 TR0 and bit 3 accumulator. Memory command 1 raises mem_rd and 2 raises mem_wr, never both. alu_op carries the ALU code (1 add, 2 subtract, 3 multiply, 4 divide, 5 shift left, 6 shift right, 0 none). mux_bus is 0 to select the constant and 1 to select the bus.
- R5: While the current word has its wait bit set and mem_ready is low, upc and every strobe hold. The word is released on the first edge with mem_ready high.
- R6: With no flow control, or with a failed condition, upc advances by one, modulo 32. A released word with the end bit goes to DONE: done is high for exactly that one cycle, upc is 0 and the strobes are low, and then the block returns to IDLE.
- R7: Flow type 1 is an absolute jump to the low five bits of the 8-bit target field. Unconditional bit 1 always takes it. Otherwise the condition selects 0 zero, 1 negative, 2 carry or 3 overflow (flags z, n, c, v).
- R8: Flow type 2 is a relative branch that adds the 8-bit target field, taken as two's complement, to upc modulo 32. It uses the same taken rule as R7.
- R9: Words 0 to 8 hold the following routines.
  - Fetch:
    - 0: PC drives the bus, MAR loads.
    - 1: read.
    - 2: wait.
    - 3: MDR loads.
    - 4: MDR drives the bus, IR loads.
  - Program-counter increment:
    - 5: PC drives the bus, TR0 loads.
    - 6: the accumulator loads with mux 0.
    - 7: ALU add with mux 1.
    - 8: TR1 drives the bus, PC loads.
- R10: Words 9 to 17 hold the test section. Every other word is all zero.
  - 9: branch +3 if zero.
  - 10: R1 drives the bus, R2 loads, jump to 16 if negative.
  - 11: subtract, jump to 13 unconditionally.
  - 12: multiply, branch -2 if carry.
  - 13: shift left, branch +4 if overflow.
  - 14: R2 drives the bus, MDR loads, write.
  - 15: end.
  - 16: divide, R7 loads, jump to 15 unconditionally.
  - 17: shift right, R0 drives the bus, end.
- R11: start has no effect in RUN or DONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the stored routine from word 0 |
| mem_ready | input | 1 | Memory has completed its access |
| flag_z | input | 1 | Datapath zero flag |
| flag_n | input | 1 | Datapath negative flag |
| flag_c | input | 1 | Datapath carry flag |
| flag_v | input | 1 | Datapath overflow flag |
| upc | output | 5 | Microprogram counter |
| busy | output | 1 | High in RUN |
| done | output | 1 | One-cycle completion pulse |
| drv_en | output | 12 | One-hot bus driver enables |
| ld_en | output | 10 | One-hot register load enables |
| tmp_ld | output | 4 | MAR, MDR, TR0 and accumulator loads |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| alu_op | output | 4 | ALU function code |
| mux_bus | output | 1 | 1 selects the bus or TR1, 0 the constant |
| mem_wait | output | 1 | Current word waits for memory |

## Verification
The assertions assume that the flags and mem_ready are stable around each clock edge, and that mem_ready eventually rises at a wait word. The bench changes inputs only on falling edges. It raises mem_ready after a bounded, chosen delay at the wait word. It sets each flag pattern before start and keeps it for the whole run, so every branch decision is taken on known values. Start pulses are also sent while the block is running and while it is in DONE, which exercises R11 without breaking those assumptions.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int TGT_W = 8;

    typedef struct packed {
        logic [3:0]       rout;
        logic [3:0]       rin;
        logic [2:0]       tmp;
        logic [1:0]       mem;
        logic [3:0]       alu;
        logic             mux;
        logic             wt;
        logic             fin;
        logic [1:0]       flow;
        logic             unc;
        logic [1:0]       cond;
        logic [TGT_W-1:0] tgt;
    } uword_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    localparam logic [3:0] DRV_R0  = 4'd1;
    localparam logic [3:0] DRV_R1  = 4'd2;
    localparam logic [3:0] DRV_R2  = 4'd3;
    localparam logic [3:0] DRV_PC  = 4'd9;
    localparam logic [3:0] DRV_MDR = 4'd10;
    localparam logic [3:0] DRV_TR1 = 4'd12;

    localparam logic [3:0] LD_R2 = 4'd3;
    localparam logic [3:0] LD_R7 = 4'd8;
    localparam logic [3:0] LD_PC = 4'd9;
    localparam logic [3:0] LD_IR = 4'd10;

    localparam logic [2:0] TMP_MAR = 3'd1;
    localparam logic [2:0] TMP_MDR = 3'd2;
    localparam logic [2:0] TMP_TR0 = 3'd3;
    localparam logic [2:0] TMP_ACC = 3'd4;

    localparam logic [1:0] MEM_RD = 2'd1;
    localparam logic [1:0] MEM_WR = 2'd2;

    localparam logic [3:0] ALU_ADD = 4'd1;
    localparam logic [3:0] ALU_SUB = 4'd2;
    localparam logic [3:0] ALU_MUL = 4'd3;
    localparam logic [3:0] ALU_DIV = 4'd4;
    localparam logic [3:0] ALU_SHL = 4'd5;
    localparam logic [3:0] ALU_SHR = 4'd6;

    localparam logic [1:0] FL_SEQ = 2'd0;
    localparam logic [1:0] FL_JMP = 2'd1;
    localparam logic [1:0] FL_BR  = 2'd2;

    localparam logic [1:0] CC_Z = 2'd0;
    localparam logic [1:0] CC_N = 2'd1;
    localparam logic [1:0] CC_C = 2'd2;
    localparam logic [1:0] CC_V = 2'd3;

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
    import ucseq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);

    function automatic uword_t prog_word(input int a);
        uword_t w;
        w = '0;
        case (a)
            // fetch routine
            0: begin w.rout = DRV_PC;  w.tmp = TMP_MAR; end
            1: w.mem = MEM_RD;
            2: w.wt = 1'b1;
            3: w.tmp = TMP_MDR;
            4: begin w.rout = DRV_MDR; w.rin = LD_IR; end
            // program-counter increment routine
            5: begin w.rout = DRV_PC;  w.tmp = TMP_TR0; end
            6: begin w.tmp = TMP_ACC;  w.mux = 1'b0; end
            7: begin w.alu = ALU_ADD;  w.mux = 1'b1; end
            8: begin w.rout = DRV_TR1; w.rin = LD_PC; end
            // flow-control test section
            9: begin w.flow = FL_BR; w.cond = CC_Z; w.tgt = 8'sd3; end
            10: begin
                w.rout = DRV_R1; w.rin = LD_R2;
                w.flow = FL_JMP; w.cond = CC_N; w.tgt = 8'd16;
            end
            11: begin w.alu = ALU_SUB; w.flow = FL_JMP; w.unc = 1'b1; w.tgt = 8'd13; end
            12: begin w.alu = ALU_MUL; w.flow = FL_BR; w.cond = CC_C; w.tgt = 8'hFE; end
            13: begin w.alu = ALU_SHL; w.flow = FL_BR; w.cond = CC_V; w.tgt = 8'd4; end
            14: begin w.rout = DRV_R2; w.tmp = TMP_MDR; w.mem = MEM_WR; end
            15: w.fin = 1'b1;
            16: begin
                w.alu = ALU_DIV; w.rin = LD_R7;
                w.flow = FL_JMP; w.unc = 1'b1; w.tgt = 8'd15;
            end
            17: begin w.alu = ALU_SHR; w.rout = DRV_R0; w.fin = 1'b1; end
            default: w = '0;
        endcase
        return w;
    endfunction

    uword_t rom [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign rom[i] = prog_word(i);
    end

    assign word = rom[addr];

endmodule

// File: rtl/ucseq_decode.sv
module ucseq_decode
#(
    parameter int N_DRV = 12,
    parameter int N_LD  = 10,
    parameter int N_TMP = 4
) (
    input  logic             en,
    input  logic [3:0]       rout,
    input  logic [3:0]       rin,
    input  logic [2:0]       tmp,
    input  logic [1:0]       mem,
    input  logic [3:0]       alu,
    input  logic             mux,
    input  logic             wt,
    output logic [N_DRV-1:0] drv_en,
    output logic [N_LD-1:0]  ld_en,
    output logic [N_TMP-1:0] tmp_ld,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [3:0]       alu_op,
    output logic             mux_bus,
    output logic             mem_wait
);

    for (genvar k = 0; k < N_DRV; k++) begin : g_drv
        assign drv_en[k] = en && (rout == 4'(k + 1));
    end

    for (genvar k = 0; k < N_LD; k++) begin : g_ld
        assign ld_en[k] = en && (rin == 4'(k + 1));
    end

    for (genvar k = 0; k < N_TMP; k++) begin : g_tmp
        assign tmp_ld[k] = en && (tmp == 3'(k + 1));
    end

    assign mem_rd   = en && (mem == 2'd1);
    assign mem_wr   = en && (mem == 2'd2);
    assign alu_op   = en ? alu : 4'd0;
    assign mux_bus  = en && mux;
    assign mem_wait = en && wt;

endmodule

// File: rtl/ucseq_next.sv
module ucseq_next
    import ucseq_pkg::*;
#(
    parameter int AW = 5,
    localparam int SW = (AW > TGT_W) ? AW : TGT_W
) (
    input  logic [AW-1:0]    upc,
    input  logic             wt,
    input  logic             ready,
    input  logic [1:0]       flow,
    input  logic             unc,
    input  logic [1:0]       cond,
    input  logic [TGT_W-1:0] tgt,
    input  logic [3:0]       flags,
    output logic             hold,
    output logic [AW-1:0]    nxt
);

    logic          taken;
    logic [SW-1:0] upc_x;
    logic [SW-1:0] off_x;
    logic [SW-1:0] sum_x;

    assign taken = unc || flags[cond];
    assign hold  = wt && !ready;
    assign upc_x = SW'(upc);
    assign off_x = SW'($signed(tgt));
    assign sum_x = upc_x + off_x;

    always_comb begin
        nxt = upc + AW'(1);
        if (hold) begin
            nxt = upc;
        end else begin
            unique case (flow)
                FL_JMP:  if (taken) nxt = tgt[AW-1:0];
                FL_BR:   if (taken) nxt = sum_x[AW-1:0];
                default: nxt = upc + AW'(1);
            endcase
        end
    end

endmodule

// File: rtl/ucseq_ctrl.sv
module ucseq_ctrl
    import ucseq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int N_DRV = 12,
    parameter int N_LD  = 10,
    parameter int N_TMP = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mem_ready,
    input  logic             flag_z,
    input  logic             flag_n,
    input  logic             flag_c,
    input  logic             flag_v,
    output logic [AW-1:0]    upc,
    output logic             busy,
    output logic             done,
    output logic [N_DRV-1:0] drv_en,
    output logic [N_LD-1:0]  ld_en,
    output logic [N_TMP-1:0] tmp_ld,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic [3:0]       alu_op,
    output logic             mux_bus,
    output logic             mem_wait
);

    seq_state_e    state;
    uword_t        w;
    logic          hold;
    logic [AW-1:0] nxt;

    ucseq_store #(.DEPTH(DEPTH)) u_store (
        .addr (upc),
        .word (w)
    );

    ucseq_next #(.AW(AW)) u_next (
        .upc   (upc),
        .wt    (w.wt),
        .ready (mem_ready),
        .flow  (w.flow),
        .unc   (w.unc),
        .cond  (w.cond),
        .tgt   (w.tgt),
        .flags ({flag_v, flag_c, flag_n, flag_z}),
        .hold  (hold),
        .nxt   (nxt)
    );

    ucseq_decode #(.N_DRV(N_DRV), .N_LD(N_LD), .N_TMP(N_TMP)) u_decode (
        .en       (busy),
        .rout     (w.rout),
        .rin      (w.rin),
        .tmp      (w.tmp),
        .mem      (w.mem),
        .alu      (w.alu),
        .mux      (w.mux),
        .wt       (w.wt),
        .drv_en   (drv_en),
        .ld_en    (ld_en),
        .tmp_ld   (tmp_ld),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .alu_op   (alu_op),
        .mux_bus  (mux_bus),
        .mem_wait (mem_wait)
    );

    // state register and microprogram counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            upc   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    upc <= '0;
                    if (start) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (w.fin && !hold) begin
                        state <= ST_DONE;
                        upc   <= '0;
                    end else begin
                        upc <= nxt;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                    upc   <= '0;
                end
                default: begin
                    state <= ST_IDLE;
                    upc   <= '0;
                end
            endcase
        end
    end

    // state-derived outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |-> (drv_en == '0 && ld_en == '0 && tmp_ld == '0 && !mem_rd && !mem_wr));

    p_start_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> (busy && upc == '0));

    p_one_driver_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));

    p_one_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_en));

    p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_wait && !mem_ready) |=> (busy && $stable(upc)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy && upc == '0));

    p_jump_uncond_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_wait && !w.fin && w.flow == FL_JMP && w.unc)
            |=> (upc == $past(w.tgt[AW-1:0])));

    p_ignore_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !busy);

endmodule

// File: tb/ucseq_ctrl_tb.sv
module ucseq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_ready = 1'b0;
    logic        flag_z = 1'b0, flag_n = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic [4:0]  upc;
    logic        busy, done;
    logic [11:0] drv_en;
    logic [9:0]  ld_en;
    logic [3:0]  tmp_ld;
    logic        mem_rd, mem_wr;
    logic [3:0]  alu_op;
    logic        mux_bus, mem_wait;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    ucseq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mem_ready(mem_ready),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
        .upc(upc), .busy(busy), .done(done), .drv_en(drv_en), .ld_en(ld_en),
        .tmp_ld(tmp_ld), .mem_rd(mem_rd), .mem_wr(mem_wr), .alu_op(alu_op),
        .mux_bus(mux_bus), .mem_wait(mem_wait)
    );

    always #5 clk = ~clk;

    // reference program, one entry per word: -1 means no strobe
    int m_drv [32];
    int m_ld  [32];
    int m_tmp [32];
    int m_mem [32];
    int m_alu [32];
    int m_mux [32];
    int m_wt  [32];
    int m_fin [32];
    int m_flow[32];
    int m_unc [32];
    int m_cond[32];
    int m_off [32];

    int    m_st  = 0;  // 0 idle, 1 run, 2 done
    int    m_upc = 0;
    string upc_tag = "R1";

    task automatic put(input int a, input int drv, input int ld, input int tmp,
                       input int mem, input int alu, input int mux, input int wt,
                       input int fin, input int flow, input int unc, input int cond,
                       input int off);
        m_drv[a] = drv; m_ld[a] = ld; m_tmp[a] = tmp; m_mem[a] = mem;
        m_alu[a] = alu; m_mux[a] = mux; m_wt[a] = wt; m_fin[a] = fin;
        m_flow[a] = flow; m_unc[a] = unc; m_cond[a] = cond; m_off[a] = off;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s at upc_model=%0d: actual=%0h expected=%0h", tag, m_upc, act, exp);
        end
    endtask

    task automatic step(input bit st, input bit rdy, input bit [3:0] fl);
        int    e_drv, e_ld, e_tmp, e_rd, e_wr, e_alu, e_mux, e_wt, nxt;
        bit    taken;
        string stag;
        @(negedge clk);
        start = st; mem_ready = rdy;
        {flag_v, flag_c, flag_n, flag_z} = fl;
        e_drv = 0; e_ld = 0; e_tmp = 0; e_rd = 0; e_wr = 0; e_alu = 0; e_mux = 0; e_wt = 0;
        if (m_st == 1) begin
            if (m_drv[m_upc] >= 0) e_drv = 1 << m_drv[m_upc];
            if (m_ld[m_upc] >= 0)  e_ld  = 1 << m_ld[m_upc];
            if (m_tmp[m_upc] >= 0) e_tmp = 1 << m_tmp[m_upc];
            e_rd  = (m_mem[m_upc] == 1) ? 1 : 0;
            e_wr  = (m_mem[m_upc] == 2) ? 1 : 0;
            e_alu = m_alu[m_upc];
            e_mux = m_mux[m_upc];
            e_wt  = m_wt[m_upc];
        end
        stag = (m_st != 1) ? "R1" : ((m_upc <= 8) ? "R9" : "R10");
        chk({upc_tag, " upc"}, int'(upc), m_upc);
        chk({upc_tag, " busy/done"}, int'({busy, done}), (m_st == 1 ? 2 : 0) + (m_st == 2 ? 1 : 0));
        chk({"R2 drv_en ", stag}, int'(drv_en), e_drv);
        chk({"R3 ld_en ", stag}, int'(ld_en), e_ld);
        chk({"R4 tmp/mem ", stag}, int'({tmp_ld, mem_rd, mem_wr}), (e_tmp << 2) | (e_rd << 1) | e_wr);
        chk({"R4 alu/mux/wait ", stag}, int'({alu_op, mux_bus, mem_wait}), (e_alu << 2) | (e_mux << 1) | e_wt);
        // model next state
        nxt = m_upc;
        case (m_st)
            0: begin
                if (st) begin m_st = 1; upc_tag = "R1"; end
                else upc_tag = "R11";
                nxt = 0;
            end
            1: begin
                if (m_wt[m_upc] != 0 && !rdy) begin
                    upc_tag = "R5";
                end else if (m_fin[m_upc] != 0) begin
                    m_st = 2; nxt = 0; upc_tag = "R6";
                end else begin
                    taken = (m_unc[m_upc] != 0) || fl[m_cond[m_upc]];
                    nxt = (m_upc + 1) % 32;
                    upc_tag = "R6";
                    if (m_flow[m_upc] == 1) begin
                        upc_tag = "R7";
                        if (taken) nxt = m_off[m_upc] % 32;
                    end else if (m_flow[m_upc] == 2) begin
                        upc_tag = "R8";
                        if (taken) nxt = (((m_upc + m_off[m_upc]) % 32) + 32) % 32;
                    end
                end
                if (st) upc_tag = {upc_tag, " R11"};
            end
            default: begin m_st = 0; nxt = 0; upc_tag = "R11"; end
        endcase
        @(posedge clk);
        m_upc = nxt;
    endtask

    task automatic run_prog(input bit [3:0] fl, input int delay);
        int  wcnt;
        bit  rdy, st;
        wcnt = 0;
        for (int i = 0; i < 80; i++) begin
            st = (i == 0) || (m_st == 2) || (i == 7);
            if (m_st == 1 && m_wt[m_upc] != 0) begin
                rdy = (wcnt >= delay);
                wcnt++;
            end else begin
                rdy = 1'b0;
                wcnt = 0;
            end
            step(st, rdy, fl);
            if (i > 0 && m_st == 0) break;
        end
        step(1'b0, 1'b0, fl);
        step(1'b0, 1'b0, fl);
    endtask

    initial begin : watchdog
        #1500000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        for (int a = 0; a < 32; a++) put(a, -1, -1, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9 fetch and program-counter increment routines
        put(0,  8, -1,  0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        put(1, -1, -1, -1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        put(2, -1, -1, -1, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        put(3, -1, -1,  1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        put(4,  9,  9, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        put(5,  8, -1,  2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        put(6, -1, -1,  3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        put(7, -1, -1, -1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        put(8, 11,  8, -1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10 test section
        put(9,  -1, -1, -1, 0, 0, 0, 0, 0, 2, 0, 0, 3);
        put(10,  1,  2, -1, 0, 0, 0, 0, 0, 1, 0, 1, 16);
        put(11, -1, -1, -1, 0, 2, 0, 0, 0, 1, 1, 0, 13);
        put(12, -1, -1, -1, 0, 3, 0, 0, 0, 2, 0, 2, -2);
        put(13, -1, -1, -1, 0, 5, 0, 0, 0, 2, 0, 3, 4);
        put(14,  2, -1,  1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        put(15, -1, -1, -1, 0, 0, 0, 0, 1, 0, 0, 0, 0);
        put(16, -1,  7, -1, 0, 4, 0, 0, 0, 1, 1, 0, 15);
        put(17,  0, -1, -1, 0, 6, 0, 0, 1, 0, 0, 0, 0);

        // R1: reset state, then idle without start
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 4'b0000);

        // flag order {v,c,n,z}
        run_prog(4'b0000, 0);  // R6 fall-through path, zero-latency memory
        run_prog(4'b0001, 3);  // R8 forward branch on zero, R5 stall
        run_prog(4'b0111, 1);  // R8 backward branch on carry, R7 jump on negative
        run_prog(4'b1001, 2);  // R8 branch on overflow, end at 17
        run_prog(4'b0010, 0);  // R7 conditional jump on negative only
        run_prog(4'b0100, 5);  // carry alone: R7 unconditional jump 11 to 13

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule